// File: doc/BRIEF.md
# Four-channel down-counter timer

The block holds four independent 8-bit down-counters. They are programmed through one byte-wide write port, which has a 2-bit channel select and a write strobe. A write with bit 0 set is a control word for the selected channel. If that word asks for it, the next write to the same channel is taken as the channel's time constant. On channel 0, a byte with bit 0 clear that is not awaited as a time constant loads the upper five bits of a shared interrupt vector.

A running channel counts down once per `tick`. When its period ends, it reloads from its time constant and pulses its `zc` bit for one clock. If the channel's interrupt is enabled, it also records a pending request. The highest-priority pending channel appears on `vector`, with its number in bits 2:1. An `ack` strobe retires that request.

Each channel is a four-state machine:
- `CH_STOP`: stopped, not awaiting a constant.
- `CH_STOP_TC`: stopped, awaiting its first constant.
- `CH_RUN`: counting.
- `CH_RUN_TC`: counting and awaiting a new constant.

Its transitions are:
- A control word with the constant-follows flag moves `CH_STOP`→`CH_STOP_TC` or `CH_RUN`→`CH_RUN_TC`.
- A control word with the stop flag moves `CH_RUN` to `CH_STOP`, or to `CH_STOP_TC` if the constant-follows flag is also set.
- A constant write moves `CH_STOP_TC`→`CH_RUN`, loading the count at once.
- A constant write moves `CH_RUN_TC`→`CH_RUN`, leaving the count alone.
- Reset forces every channel to `CH_STOP`.

Top module: `quad_countdown_timer`

## Requirements
- R1: After `rst_n` is low, every channel is in `CH_STOP` with no pending request and no awaited constant. The vector register is 0, so `irq`=0, `vector`=8'h00 and `zc`=0.
- R2: A write with bit 0 = 1 to a channel not awaiting a constant is a control word. In it, bit 7 = interrupt enable, bit 2 = a constant follows, and bit 1 = stop counting.
- R3: A constant is taken only on the next write to the same channel after a control word with bit 2 set, whatever that byte's bit 0 is. Any other write with bit 0 = 0 to channels 1–3 has no effect.
- R4: A constant of N gives a period of N ticks, and 8'h00 means 256 ticks.
- R5: At the end of a period the channel reloads, and its `zc` bit is 1 for exactly the clock after the edge that took the last tick.
- R6: A stopped channel given a constant counts from the first tick after the constant write.
- R7: A constant written to a running channel does not change the count in progress. It takes effect at the next reload.
- R8: A write to channel 0 with bit 0 = 0 while channel 0 awaits no constant stores data bits 7:3 as the vector's upper bits. Data bits 2:0 are discarded.
- R9: `vector` = {stored bits 7:3, selected channel number in bits 2:1, 0 in bit 0}. With nothing pending, the channel field is 0.
- R10: A pending flag is set at a channel's period end only when its interrupt is enabled. Flags hold until acknowledged, and `irq` is high while any flag is set.
- R11: Among pending channels, channel 0 wins and channel 3 loses.
- R12: `ack` clears the pending flag of the channel shown on `vector`. With nothing pending it has no effect.
- R13: A control word with the stop bit halts the channel immediately. After it, no `zc` pulse or new request comes from that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable shared by all channels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Channel addressed by the write |
| wr_data | input | 8 | Write byte |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Any request pending |
| vector | output | 8 | Interrupt vector |
| zc | output | 4 | Per-channel end-of-period pulse |

## Verification
A channel stuck in the wrong state shows up on the first write or tick after the fault. A lost awaited-constant state lets a byte leak into the vector register or vanish. A wrong running state moves or drops the next `zc` pulse by whole ticks. A corrupted count or a reload taken from the wrong constant puts `zc` at the wrong tick within one period, at most 256 ticks. A bad pending flag or priority encoder shows on `vector` and `irq` on the very next cycle, and the scoreboard catches it at the acknowledge that follows.

// File: rtl/qct_pkg.sv
package qct_pkg;
    localparam int DATA_W  = 8;
    localparam int NCH     = 4;
    localparam int SEL_W   = $clog2(NCH);
    // control word bit positions
    localparam int CTL_IS  = 0;
    localparam int CTL_STP = 1;
    localparam int CTL_TCF = 2;
    localparam int CTL_IEN = 7;
    localparam int VEC_LO  = SEL_W + 1;

    typedef enum logic [1:0] {
        CH_STOP    = 2'd0,
        CH_STOP_TC = 2'd1,
        CH_RUN     = 2'd2,
        CH_RUN_TC  = 2'd3
    } chan_state_e;
endpackage

// File: rtl/qct_channel.sv
module qct_channel
    import qct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic              zc,
    output logic              exp_tc,
    output logic              ien
);
    localparam int CW = DATA_W + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << DATA_W;

    chan_state_e st, st_nx;
    logic [DATA_W-1:0] tc_q;
    logic [CW-1:0]     cnt_q;
    logic              running, tc_wr, is_ctrl, stop_now;

    function automatic logic [CW-1:0] reload(input logic [DATA_W-1:0] v);
        return (v == '0) ? FULL : {1'b0, v};
    endfunction

    assign exp_tc   = (st == CH_STOP_TC) || (st == CH_RUN_TC);
    assign running  = (st == CH_RUN) || (st == CH_RUN_TC);
    assign tc_wr    = wr && exp_tc;
    assign is_ctrl  = wr && !exp_tc && wdata[CTL_IS];
    assign stop_now = is_ctrl && wdata[CTL_STP];
    assign hit      = running && tick && !stop_now && (cnt_q == CW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= CH_STOP;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            CH_STOP:    if (is_ctrl) st_nx = wdata[CTL_TCF] ? CH_STOP_TC : CH_STOP;
            CH_STOP_TC: if (tc_wr)   st_nx = CH_RUN;
            CH_RUN:
                if (is_ctrl) begin
                    if (wdata[CTL_STP]) st_nx = wdata[CTL_TCF] ? CH_STOP_TC : CH_STOP;
                    else                st_nx = wdata[CTL_TCF] ? CH_RUN_TC  : CH_RUN;
                end
            CH_RUN_TC:  if (tc_wr)   st_nx = CH_RUN;
            default:    st_nx = CH_STOP;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q  <= '0;
            cnt_q <= FULL;
            ien   <= 1'b0;
            zc    <= 1'b0;
        end else begin
            zc <= hit;
            if (is_ctrl) ien  <= wdata[CTL_IEN];
            if (tc_wr)   tc_q <= wdata;
            if (tc_wr && st == CH_STOP_TC)
                cnt_q <= reload(wdata);
            else if (hit)
                cnt_q <= reload(tc_wr ? wdata : tc_q);
            else if (running && tick && !stop_now)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    // R5
    zc_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zc |-> $past(tick));
    // R13
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_STOP || st == CH_STOP_TC) |=> !zc);
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q != '0 && cnt_q <= FULL));
endmodule

// File: rtl/qct_prio.sv
module qct_prio
    import qct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    set,
    input  logic              ack,
    input  logic              vec_wr,
    input  logic [DATA_W-1:VEC_LO] vec_data,
    output logic              irq,
    output logic [DATA_W-1:0] vector
);
    logic [NCH-1:0]           pend_q, clr;
    logic [SEL_W-1:0]         sel;
    logic [DATA_W-1:VEC_LO]   vhi_q;

    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (pend_q[i]) sel = SEL_W'(i);
    end

    assign irq    = |pend_q;
    assign clr    = (ack && irq) ? (NCH'(1) << sel) : '0;
    assign vector = {vhi_q, sel, 1'b0};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            vhi_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | set;
            if (vec_wr) vhi_q <= vec_data;
        end
    end

    // R12
    ack_retires_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && set == '0) |=> ($countones(pend_q) == $past($countones(pend_q)) - 1));
    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && set == '0) |=> $stable(pend_q));
    // R9
    vec_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend_q[vector[SEL_W:1]]);
endmodule

// File: rtl/quad_countdown_timer.sv
module quad_countdown_timer
    import qct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack,
    output logic              irq,
    output logic [DATA_W-1:0] vector,
    output logic [NCH-1:0]    zc
);
    logic [NCH-1:0] hit, ien, exp_tc, ch_wr;
    logic           vec_wr;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_wr[g] = wr_en && (wr_sel == SEL_W'(g));
        qct_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .wr     (ch_wr[g]),
            .wdata  (wr_data),
            .hit    (hit[g]),
            .zc     (zc[g]),
            .exp_tc (exp_tc[g]),
            .ien    (ien[g])
        );
    end

    assign vec_wr = ch_wr[0] && !wr_data[CTL_IS] && !exp_tc[0];

    qct_prio u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (hit & ien),
        .ack      (ack),
        .vec_wr   (vec_wr),
        .vec_data (wr_data[DATA_W-1:VEC_LO]),
        .irq      (irq),
        .vector   (vector)
    );

    // R8
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_wr |=> vector[DATA_W-1:VEC_LO] == $past(wr_data[DATA_W-1:VEC_LO]));
endmodule

// File: tb/sim_quad_countdown_timer.sv
module sim_quad_countdown_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       ack = 1'b0;
    logic       irq;
    logic [7:0] vector;
    logic [3:0] zc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct { logic [7:0] vec; string req; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    quad_countdown_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ack(ack), .irq(irq), .vector(vector), .zc(zc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ack_expect(input logic [7:0] v, input string req);
        exp_q.push_back('{vec: v, req: req});
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // monitor: compares the vector seen during each acknowledge
    always @(negedge clk) begin
        #1;
        if (ack) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-empty", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, vector, e.vec);
            end
        end
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 vector", vector, 8'h00);
        check("R1 zc", zc, 0);

        // R8 vector load, low bits dropped
        put(0, 8'hA8);
        check("R8 vector", vector, 8'hA8);
        put(0, 8'hAE);
        check("R8 low bits", vector, 8'hA8);

        // R2 R6 R5 channel 2, constant 3
        put(2, 8'h85);
        put(2, 8'h03);
        ticks(2);
        check("R6 early", zc, 4'b0000);
        ticks(1);
        check("R5 pulse", zc, 4'b0100);
        check("R10 irq", irq, 1);
        check("R9 vector ch2", vector, 8'hAC);
        @(negedge clk);
        check("R5 one cycle", zc, 4'b0000);
        ack_expect(8'hAC, "R12 ack ch2");
        check("R12 irq clear", irq, 0);
        ack_expect(8'hA8, "R12 ack empty");
        check("R12 empty no effect", irq, 0);

        // R13 stop
        put(2, 8'h03);
        ticks(5);
        check("R13 zc", zc, 4'b0000);
        check("R13 irq", irq, 0);

        // R4 zero means 256, R10 disabled interrupt
        put(1, 8'h05);
        put(1, 8'h00);
        ticks(255);
        check("R4 before 256", zc, 4'b0000);
        ticks(1);
        check("R4 at 256", zc, 4'b0010);
        check("R10 disabled", irq, 0);
        put(1, 8'h03);

        // R11 priority
        put(3, 8'h85); put(3, 8'h02);
        put(0, 8'h85); put(0, 8'h04);
        ticks(4);
        check("R11 both expire", zc, 4'b1001);
        check("R11 ch0 first", vector, 8'hA8);
        put(0, 8'h03); put(3, 8'h03);
        ack_expect(8'hA8, "R11 ack ch0");
        check("R11 ch3 next", vector, 8'hAE);
        ack_expect(8'hAE, "R12 ack ch3");
        check("R12 all clear", irq, 0);

        // R7 deferred reload
        put(1, 8'h85); put(1, 8'h05);
        ticks(2);
        put(1, 8'h85); put(1, 8'h02);
        ticks(2);
        check("R7 old count kept", zc, 4'b0000);
        ticks(1);
        check("R7 first period 5", zc, 4'b0010);
        ticks(1);
        check("R7 new period mid", zc, 4'b0000);
        ticks(1);
        check("R7 new period 2", zc, 4'b0010);
        ack_expect(8'hAA, "R10 held ch1");
        put(1, 8'h03);
        check("R10 retired", irq, 0);

        // R3 byte without control is ignored on channel 3
        put(3, 8'h81);
        put(3, 8'h02);
        ticks(5);
        check("R3 ignored", zc, 4'b0000);
        check("R3 no irq", irq, 0);
        // R3 awaited constant on channel 0 is not a vector write
        put(0, 8'h85);
        put(0, 8'h02);
        ticks(2);
        check("R3 ch0 constant", zc, 4'b0001);
        check("R3 vector kept", vector, 8'hA8);
        ack_expect(8'hA8, "R3 ack ch0");

        // R1 reset clears awaited constant and stops channels
        put(2, 8'h85);
        ticks(1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", irq, 0);
        check("R1 vector after reset", vector, 8'h00);
        put(2, 8'h02);
        ticks(4);
        check("R1 stopped", zc, 4'b0000);

        @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule